// File: doc/BRIEF.md
# Funnel Shift-Right Unit

This unit shifts a destination word right by a count. The bit positions that the shift empties at the top are filled with the low bits of a second source word. The result is the low word of the source:destination pair after that pair has been shifted right as one double-width value. It is built for multiword shifts, where a wide value is moved across several words one word at a time. The unit handles 16-bit and 32-bit operands. Only the low five bits of the count are used.

For a nonzero count, the unit also computes new carry, overflow, sign, zero and parity flags. It raises a flag-write enable so that a downstream flag register picks them up. A zero count leaves the result and all flags as they were. A count that is larger than a 16-bit operand has no defined result. In that case the unit raises an undefined-result indicator and returns the destination and the incoming flags unchanged, so the behaviour stays deterministic. The unit is one pipeline stage: every output is registered and shows the operation one clock edge after the valid strobe.

Top module: `fsr_unit`

## Requirements
- R1: Only `count_in[4:0]` forms the effective count (0 to 31), so a count of 33 acts as 1 and a count of 32 acts as 0.
- R2: `wide_sel`=1 selects 32-bit operands and `wide_sel`=0 selects 16-bit operands. In 16-bit mode, input bits 31:16 are ignored and `res_out[31:16]` is always zero.
- R3: An effective count of zero returns the destination as the result, copies `flags_in` to `flags_out` unchanged, and keeps `flag_we` and `undef_out` low.
- R4: For an effective count n with 1 <= n <= size, result bit i is `dst_in[i+n]` for i <= size-1-n. Otherwise result bit i is `src_in[i+n-size]`.
- R5: For 1 <= n <= size, carry (`flags_out[0]`) is `dst_in[n-1]`, the last bit shifted out.
- R6: Overflow is `flags_out[5]`. For n=1 it is set when the result MSB differs from the original destination MSB. For n>1 it equals the incoming overflow.
- R7: For 1 <= n <= size:
  - sign (`flags_out[4]`) is the result MSB.
  - zero (`flags_out[3]`) is set when the result is all zeros.
  - parity (`flags_out[1]`) is set when the low 8 result bits hold an even number of ones.
  - auxiliary (`flags_out[2]`) always equals its incoming value.
- R8: In 16-bit mode with n > 16:
  - `undef_out` goes high and `flag_we` stays low.
  - The result is the 16-bit destination.
  - `flags_out` equals `flags_in`.
- R9: Outputs load on the rising edge where `in_valid` is high. `res_out` and `flags_out` hold their values while `in_valid` is low. `flag_we` (high only for a defined nonzero count) and `undef_out` are one-cycle pulses that are never high together.
- R10: A synchronous active-high `rst` clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| dst_in | input | 32 | Destination word being shifted |
| src_in | input | 32 | Source word supplying fill bits |
| count_in | input | 8 | Shift count (low 5 bits used) |
| wide_sel | input | 1 | 1: 32-bit operands, 0: 16-bit operands |
| flags_in | input | 6 | Incoming flags {OF,SF,ZF,AF,PF,CF} |
| res_out | output | 32 | Registered result |
| flags_out | output | 6 | Registered flags {OF,SF,ZF,AF,PF,CF} |
| flag_we | output | 1 | Pulse: flags_out carries new flags |
| undef_out | output | 1 | Pulse: count exceeded operand size |

## Verification
The assertions assume that all inputs are free of X or Z whenever `in_valid` is high, and that the count's upper three bits may hold any value. The holding properties also assume that `in_valid` is only a single-cycle request with no back-pressure, so every accepted strobe updates the outputs. The stimulus drives every input on the falling clock edge and lowers `in_valid` after each operation, so every request is seen at exactly one rising edge. It also puts random-looking values on the upper operand bits in 16-bit mode and on the unused count bits, which confirms that those bits are ignored.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  // Flag vector layout, MSB to LSB: overflow, sign, zero, aux, parity, carry
  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } fsr_flags_t;

  localparam int FLAG_W = 6;
endpackage

// File: rtl/fsr_count_dec.sv
module fsr_count_dec #(
  parameter int W     = 32,
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0]         count_in,
  input  logic                     wide_sel,
  output logic [$clog2(W)-1:0]     cnt_eff,
  output logic                     cnt_zero,
  output logic                     cnt_one,
  output logic                     cnt_over
);
  localparam int KEEP = $clog2(W);
  localparam int H    = W / 2;

  always_comb begin
    cnt_eff  = count_in[KEEP-1:0];
    cnt_zero = (cnt_eff == '0);
    cnt_one  = (cnt_eff == KEEP'(1));
    // only the narrow size can be exceeded by a masked count
    cnt_over = !wide_sel && ({1'b0, cnt_eff} > (KEEP+1)'(H));
  end
endmodule

// File: rtl/fsr_funnel.sv
module fsr_funnel #(
  parameter int W = 32
) (
  input  logic [W-1:0]         dst_in,
  input  logic [W-1:0]         src_in,
  input  logic [$clog2(W)-1:0] cnt,
  input  logic                 wide_sel,
  output logic [W-1:0]         dst_m,
  output logic [W-1:0]         shifted,
  output logic                 bit_out
);
  localparam int H    = W / 2;
  localparam int KEEP = $clog2(W);

  // Shift the concatenated pair {hi,lo} right and keep the low word.
  function automatic logic [W-1:0] funnel_right(
    input logic [W-1:0] hi, input logic [W-1:0] lo,
    input logic [KEEP-1:0] n, input logic wide
  );
    logic [2*W-1:0] cat;
    logic [2*W-1:0] sh;
    cat = wide ? {hi, lo} : {{W{1'b0}}, hi[H-1:0], lo[H-1:0]};
    sh  = cat >> n;
    return wide ? sh[W-1:0] : {{H{1'b0}}, sh[H-1:0]};
  endfunction

  logic [W-1:0] out_sel;

  always_comb begin
    dst_m   = wide_sel ? dst_in : {{H{1'b0}}, dst_in[H-1:0]};
    shifted = funnel_right(src_in, dst_in, cnt, wide_sel);
    out_sel = dst_m >> (cnt - KEEP'(1));
    bit_out = out_sel[0];
  end
endmodule

// File: rtl/fsr_flag_gen.sv
module fsr_flag_gen #(
  parameter int W = 32
) (
  input  logic [W-1:0]           res,
  input  logic [W-1:0]           dst_m,
  input  logic                   wide_sel,
  input  logic                   cnt_one,
  input  logic                   bit_out,
  input  fsr_pkg::fsr_flags_t    flags_in,
  output fsr_pkg::fsr_flags_t    flags_new
);
  localparam int H = W / 2;

  function automatic logic top_bit(input logic [W-1:0] v, input logic wide);
    return wide ? v[W-1] : v[H-1];
  endfunction

  logic res_msb;
  logic dst_msb;

  always_comb begin
    res_msb       = top_bit(res, wide_sel);
    dst_msb       = top_bit(dst_m, wide_sel);
    flags_new.cry = bit_out;
    flags_new.ovf = cnt_one ? (res_msb ^ dst_msb) : flags_in.ovf;
    flags_new.sgn = res_msb;
    flags_new.zro = (res == '0);
    flags_new.par = ~^res[7:0];
    flags_new.aux = flags_in.aux;
  end
endmodule

// File: rtl/fsr_unit.sv
module fsr_unit #(
  parameter int W     = 32,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [W-1:0]     dst_in,
  input  logic [W-1:0]     src_in,
  input  logic [CNT_W-1:0] count_in,
  input  logic             wide_sel,
  input  logic [5:0]       flags_in,
  output logic [W-1:0]     res_out,
  output logic [5:0]       flags_out,
  output logic             flag_we,
  output logic             undef_out
);
  import fsr_pkg::*;
  localparam int KEEP = $clog2(W);
  localparam int H    = W / 2;

  logic [KEEP-1:0] cnt_eff;
  logic            cnt_zero;
  logic            cnt_one;
  logic            cnt_over;
  logic [W-1:0]    dst_m;
  logic [W-1:0]    shifted;
  logic            bit_out;
  fsr_flags_t      flags_new;
  logic            do_shift;

  fsr_count_dec #(.W(W), .CNT_W(CNT_W)) u_dec (
    .count_in (count_in),
    .wide_sel (wide_sel),
    .cnt_eff  (cnt_eff),
    .cnt_zero (cnt_zero),
    .cnt_one  (cnt_one),
    .cnt_over (cnt_over)
  );

  fsr_funnel #(.W(W)) u_funnel (
    .dst_in   (dst_in),
    .src_in   (src_in),
    .cnt      (cnt_eff),
    .wide_sel (wide_sel),
    .dst_m    (dst_m),
    .shifted  (shifted),
    .bit_out  (bit_out)
  );

  fsr_flag_gen #(.W(W)) u_flags (
    .res       (shifted),
    .dst_m     (dst_m),
    .wide_sel  (wide_sel),
    .cnt_one   (cnt_one),
    .bit_out   (bit_out),
    .flags_in  (fsr_flags_t'(flags_in)),
    .flags_new (flags_new)
  );

  assign do_shift = !cnt_zero && !cnt_over;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out   <= '0;
      flags_out <= '0;
      flag_we   <= 1'b0;
      undef_out <= 1'b0;
    end else begin
      flag_we   <= in_valid && do_shift;
      undef_out <= in_valid && cnt_over;
      if (in_valid) begin
        res_out   <= do_shift ? shifted : dst_m;
        flags_out <= do_shift ? 6'(flags_new) : flags_in;
      end
    end
  end

  // ---------------- assertions ----------------
  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (res_out == '0) && (flags_out == '0) && !flag_we && !undef_out);

  assert_zero_count_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && count_in[KEEP-1:0] == '0) |=>
      !flag_we && !undef_out && (flags_out == $past(flags_in)));

  assert_undef_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide_sel && count_in[KEEP-1:0] > KEEP'(H)) |=>
      undef_out && !flag_we && (flags_out == $past(flags_in)));

  assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(flag_we && undef_out));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(res_out) && $stable(flags_out) && !flag_we && !undef_out);

  assert_aux_pass_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> flags_out[2] == $past(flags_in[2]));

  assert_narrow_upper_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide_sel) |=> res_out[W-1:H] == '0);
endmodule

// File: tb/fsr_unit_bench.sv
module fsr_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] dst_in, src_in;
  logic [7:0]  count_in;
  logic        wide_sel;
  logic [5:0]  flags_in;
  logic [31:0] res_out;
  logic [5:0]  flags_out;
  logic        flag_we, undef_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk; // 50 MHz

  fsr_unit u_fsr_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .dst_in(dst_in),
    .src_in(src_in), .count_in(count_in), .wide_sel(wide_sel),
    .flags_in(flags_in), .res_out(res_out), .flags_out(flags_out),
    .flag_we(flag_we), .undef_out(undef_out)
  );

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference model written bit by bit from the requirements
  task automatic model(input logic [31:0] d, input logic [31:0] s, input logic [7:0] c,
                       input logic w, input logic [5:0] fi,
                       output logic [31:0] r, output logic [5:0] fo,
                       output logic we, output logic un);
    int n, sz;
    n = int'(c) % 32;
    sz = w ? 32 : 16;
    r = '0; fo = fi; we = 0; un = 0;
    if (n == 0 || n > sz) begin
      for (int i = 0; i < sz; i++) r[i] = d[i];
      un = (n > sz);
    end else begin
      for (int i = 0; i < sz; i++)
        r[i] = (i <= sz - 1 - n) ? d[i+n] : s[i+n-sz];
      we = 1;
      fo[0] = d[n-1];
      if (n == 1) fo[5] = r[sz-1] ^ d[sz-1];
      fo[4] = r[sz-1];
      fo[3] = (r == 0);
      fo[1] = ~^r[7:0];
    end
  endtask

  task automatic run_op(input string req, input logic [31:0] d, input logic [31:0] s,
                        input logic [7:0] c, input logic w, input logic [5:0] fi);
    logic [31:0] er; logic [5:0] ef; logic ew, eu;
    model(d, s, c, w, fi, er, ef, ew, eu);
    @(negedge clk);
    dst_in = d; src_in = s; count_in = c; wide_sel = w; flags_in = fi; in_valid = 1;
    @(posedge clk); #1;
    in_valid = 0;
    check(req, {res_out, flags_out, flag_we, undef_out}, {er, ef, ew, eu});
  endtask

  task automatic t_reset;
    rst = 1; in_valid = 0; dst_in = 0; src_in = 0; count_in = 0; wide_sel = 1; flags_in = 0;
    repeat (2) @(posedge clk); #1;
    check("R10 reset", {res_out, flags_out, flag_we, undef_out}, 40'd0);
    @(negedge clk); rst = 0;
  endtask

  task automatic t_wide;
    run_op("R4 R5 wide n=4",  32'h1234_5678, 32'h9ABC_DEF0, 8'd4,  1, 6'b000000);
    run_op("R4 R5 wide n=16", 32'hCAFE_BABE, 32'h0F0F_1234, 8'd16, 1, 6'b111111);
    run_op("R4 R5 wide n=31", 32'h8000_0001, 32'hFFFF_FFFE, 8'd31, 1, 6'b000100);
    run_op("R6 wide n=1 sign change", 32'h8000_0001, 32'h0000_0000, 8'd1, 1, 6'b000000);
  endtask

  task automatic t_narrow;
    run_op("R2 R4 narrow n=1",  32'hDEAD_8003, 32'hBEEF_0001, 8'd1,  0, 6'b100000);
    run_op("R2 R4 narrow n=8",  32'h5555_ABCD, 32'hAAAA_1234, 8'd8,  0, 6'b000000);
    run_op("R2 R5 narrow n=15", 32'hFFFF_4000, 32'h1111_7FFF, 8'd15, 0, 6'b010101);
    run_op("R2 R5 narrow n=16", 32'h0000_8000, 32'hFFFF_00F0, 8'd16, 0, 6'b000000);
  endtask

  task automatic t_zero;
    run_op("R3 zero count wide",   32'h1357_9BDF, 32'hFFFF_FFFF, 8'd0,  1, 6'b101010);
    run_op("R3 R1 count 32 narrow", 32'hAAAA_1234, 32'h5555_5555, 8'd32, 0, 6'b010101);
    run_op("R1 R3 count 64 wide",  32'h0000_0001, 32'h8000_0000, 8'd64, 1, 6'b111111);
  endtask

  task automatic t_mask;
    run_op("R1 count 33 acts as 1", 32'h0000_0003, 32'h0000_0001, 8'd33,  1, 6'b000000);
    run_op("R1 count 0xE5 acts as 5", 32'hF0F0_0F0F, 32'h1234_5678, 8'hE5, 1, 6'b000000);
  endtask

  task automatic t_undef;
    run_op("R8 narrow n=17", 32'h1234_ABCD, 32'hFFFF_FFFF, 8'd17,  0, 6'b110011);
    run_op("R8 narrow n=31", 32'hFFFF_0001, 32'h0000_0000, 8'd31,  0, 6'b001100);
    run_op("R8 R1 narrow 0x91", 32'h0000_7777, 32'h1111_1111, 8'h91, 0, 6'b000000);
  endtask

  task automatic t_flags;
    run_op("R7 zero result", 32'h0000_0001, 32'h0000_0000, 8'd1, 1, 6'b000000);
    run_op("R6 n>1 keeps OF=1", 32'h8000_0000, 32'h0000_0000, 8'd2, 1, 6'b100000);
    run_op("R6 n>1 keeps OF=0", 32'h0000_0000, 32'hFFFF_FFFF, 8'd3, 1, 6'b000000);
    run_op("R7 odd parity", 32'h0000_0100, 32'h0, 8'd1, 1, 6'b000100);
    run_op("R7 sign narrow", 32'h0000_0000, 32'h0000_0001, 8'd16, 0, 6'b000000);
  endtask

  task automatic t_hold;
    logic [31:0] r0; logic [5:0] f0;
    run_op("R9 op before hold", 32'hA5A5_5A5A, 32'h3C3C_C3C3, 8'd7, 1, 6'b000000);
    r0 = res_out; f0 = flags_out;
    @(negedge clk); dst_in = 32'hFFFF_FFFF; count_in = 8'd1; flags_in = 6'h3F;
    repeat (2) @(posedge clk); #1;
    check("R9 hold while idle", {res_out, flags_out, flag_we, undef_out}, {r0, f0, 1'b0, 1'b0});
    run_op("R9 undef pulse", 32'h1, 32'h2, 8'd20, 0, 6'b0);
    @(posedge clk); #1;
    check("R9 pulse drops", {38'd0, flag_we, undef_out}, 40'd0);
  endtask

  initial begin
    t_reset;
    t_wide;
    t_narrow;
    t_zero;
    t_mask;
    t_undef;
    t_flags;
    t_hold;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule